// File: doc/BRIEF.md
# Debug Register Access Guard with Freeze Control

This block sits beside a small bank of debug support registers: a sticky cause register that collects exception events, an enable mask that chooses which causes matter, and a transfer data register used to exchange data with an external debugger. For every register access it decides whether the access is carried out, silently dropped or turned into a program-interrupt trap. The decision depends on the processor privilege bit, on whether debug mode is enabled and on whether the core is currently in debug mode. A read of the cause register may also clear it, depending on the same conditions.

While debug mode is disabled, the block also drives a freeze output. Freeze lets a software monitor signal the rest of the chip that debug software is running. An enabled exception event sets freeze. A return-from-interrupt releases it only when the cause register has already been cleared. Nested exceptions can therefore return without releasing freeze; only the outermost handler clears the cause register before its final return.

Top module: `dbgreg_guard`

## Requirements
- R1: An access with `priv_user`=1 changes no register. One cycle after the access, `trap` is 1 and `rd_data` is 0. The cause register is unchanged apart from any event bits set in the same cycle.
- R2: A supervisor read with `dbg_en`=0 returns the selected register one cycle later. Select encoding: 0 = cause, 1 = mask, 2 = transfer data, 3 = unmapped. A read of select 0 also clears the cause register.
- R3: A supervisor read with `dbg_en`=1 and `in_dbg`=0 returns the selected register one cycle later and leaves the cause register unchanged.
- R4: A supervisor read with `dbg_en`=1 and `in_dbg`=1 returns the selected register one cycle later. A read of select 0 also clears the cause register.
- R5: A supervisor write with `dbg_en`=0 updates the mask (select 1). Writes to the cause register (select 0) and to the transfer data register (select 2) are discarded.
- R6: A supervisor write with `dbg_en`=1 and `in_dbg`=0 is discarded, whatever the select.
- R7: A supervisor write with `dbg_en`=1 and `in_dbg`=1 updates the mask and the transfer data register. A write to the cause register is discarded.
- R8: A cycle with `evt_valid`=1 ORs `evt_cause & mask` into the cause register. If that product is nonzero and `dbg_en`=0, `freeze` is 1 from the next cycle on. Cause bits that are not enabled in the mask have no effect.
- R9: When `rfi` is high and the cause register is all zeros, `freeze` drops in the next cycle. When `rfi` is high and the cause register is nonzero, `freeze` stays high. A freeze-setting event in the same cycle as `rfi` wins.
- R10: When a clearing read of the cause register and an enabled event occur in the same cycle, the read returns the old value and the cause register then holds the new event bits.
- R11: `trap` is high for exactly one cycle per user-mode access. `rd_data` is 0 in the cycle after any write, any trapped access, an unmapped read, or no access.
- R12: A synchronous reset clears the cause register, the mask, the transfer data register, `freeze`, `trap` and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access request this cycle |
| acc_sel | input | 2 | Register select: 0 cause, 1 mask, 2 transfer data, 3 unmapped |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | W | Write data |
| priv_user | input | 1 | Privilege bit, 1 = user mode |
| dbg_en | input | 1 | Debug mode enabled |
| in_dbg | input | 1 | Core is currently in debug mode |
| evt_valid | input | 1 | Exception event pulse |
| evt_cause | input | W | Cause bits of the event |
| rfi | input | 1 | Return-from-interrupt pulse |
| rd_data | output | W | Registered read data |
| trap | output | 1 | Program-interrupt pulse |
| freeze | output | 1 | Freeze indication |

## Verification
Each access result is due one clock after the access: `rd_data` and `trap` carry it, and register updates can be seen on a read issued in the next cycle. Freeze follows an event or a return-from-interrupt after one edge. The bench drives each stimulus on a falling edge, removes it on the next falling edge, and samples there, which is one rising edge later. State is read back through non-clearing supervisor reads (`dbg_en`=1, `in_dbg`=0). A sweep covers every combination of privilege, debug enable, debug mode, select and direction, and directed sequences cover nested freeze and a clearing read that collides with an event.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;
   typedef enum logic [1:0] {
      SEL_CAUSE = 2'd0,
      SEL_MASK  = 2'd1,
      SEL_XFER  = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/dbgreg_policy.sv
module dbgreg_policy
   import dbgreg_pkg::*;
(
   input  logic       acc_valid,
   input  logic       acc_write,
   input  logic [1:0] acc_sel,
   input  logic       priv_user,
   input  logic       dbg_en,
   input  logic       in_dbg,
   output logic       do_read,
   output logic       do_clear,
   output logic       wr_mask,
   output logic       wr_xfer,
   output logic       trap_req
);
   logic sup_acc;
   logic wr_allowed;
   logic clr_mode;

   always_comb begin
      sup_acc    = acc_valid && !priv_user;
      trap_req   = acc_valid && priv_user;
      clr_mode   = !dbg_en || in_dbg;
      do_read    = sup_acc && !acc_write && (acc_sel != SEL_NONE);
      do_clear   = do_read && (acc_sel == SEL_CAUSE) && clr_mode;
      wr_allowed = sup_acc && acc_write && clr_mode;
      wr_mask    = wr_allowed && (acc_sel == SEL_MASK);
      wr_xfer    = wr_allowed && (acc_sel == SEL_XFER) && dbg_en && in_dbg;
   end
endmodule

// File: rtl/dbgreg_cause.sv
module dbgreg_cause #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic [W-1:0] set_bits,
   output logic [W-1:0] cause_q
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst)              cause_q[b] <= 1'b0;
         else if (set_bits[b]) cause_q[b] <= 1'b1;
         else if (clr)         cause_q[b] <= 1'b0;
      end
   end

   assert_evt_wins_R10: assert property (@(posedge clk) disable iff (rst)
      (|set_bits) |=> ((cause_q & $past(set_bits)) == $past(set_bits)));
   assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
      (clr && set_bits == '0) |=> (cause_q == '0));
endmodule

// File: rtl/dbgreg_freeze.sv
module dbgreg_freeze (
   input  logic clk,
   input  logic rst,
   input  logic dbg_en,
   input  logic evt_hit,
   input  logic rfi,
   input  logic cause_zero,
   output logic freeze
);
   logic frz_set;
   logic frz_rel;

   always_comb begin
      frz_set = evt_hit && !dbg_en;
      frz_rel = rfi && cause_zero;
   end

   always_ff @(posedge clk) begin
      if (rst)          freeze <= 1'b0;
      else if (frz_set) freeze <= 1'b1;
      else if (frz_rel) freeze <= 1'b0;
   end

   assert_freeze_set_R8: assert property (@(posedge clk) disable iff (rst)
      (evt_hit && !dbg_en) |=> freeze);
   assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (freeze && rfi && !cause_zero) |=> freeze);
   assert_freeze_release_R9: assert property (@(posedge clk) disable iff (rst)
      (rfi && cause_zero && !(evt_hit && !dbg_en)) |=> !freeze);
endmodule

// File: rtl/dbgreg_guard.sv
module dbgreg_guard
   import dbgreg_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         acc_valid,
   input  logic [1:0]   acc_sel,
   input  logic         acc_write,
   input  logic [W-1:0] acc_wdata,
   input  logic         priv_user,
   input  logic         dbg_en,
   input  logic         in_dbg,
   input  logic         evt_valid,
   input  logic [W-1:0] evt_cause,
   input  logic         rfi,
   output logic [W-1:0] rd_data,
   output logic         trap,
   output logic         freeze
);
   localparam int SEL_W = $bits(reg_sel_e);

   if (W < 1 || W > 64) begin : g_bad_w
      $error("dbgreg_guard: W must be within 1..64");
   end
   if (SEL_W != 2) begin : g_bad_sel
      $error("dbgreg_guard: select encoding must be two bits wide");
   end

   logic         do_read, do_clear, wr_mask, wr_xfer, trap_req;
   logic [W-1:0] cause_q, mask_q, xfer_q, set_bits, rd_mux;

   dbgreg_policy u_policy (
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_sel   (acc_sel),
      .priv_user (priv_user),
      .dbg_en    (dbg_en),
      .in_dbg    (in_dbg),
      .do_read   (do_read),
      .do_clear  (do_clear),
      .wr_mask   (wr_mask),
      .wr_xfer   (wr_xfer),
      .trap_req  (trap_req)
   );

   always_comb set_bits = evt_valid ? (evt_cause & mask_q) : '0;

   dbgreg_cause #(.W(W)) u_cause (
      .clk      (clk),
      .rst      (rst),
      .clr      (do_clear),
      .set_bits (set_bits),
      .cause_q  (cause_q)
   );

   dbgreg_freeze u_freeze (
      .clk        (clk),
      .rst        (rst),
      .dbg_en     (dbg_en),
      .evt_hit    (|set_bits),
      .rfi        (rfi),
      .cause_zero (cause_q == '0),
      .freeze     (freeze)
   );

   always_comb begin
      case (acc_sel)
         SEL_CAUSE: rd_mux = cause_q;
         SEL_MASK:  rd_mux = mask_q;
         SEL_XFER:  rd_mux = xfer_q;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_q  <= '0;
         xfer_q  <= '0;
         rd_data <= '0;
         trap    <= 1'b0;
      end else begin
         if (wr_mask) mask_q <= acc_wdata;
         if (wr_xfer) xfer_q <= acc_wdata;
         rd_data <= do_read ? rd_mux : '0;
         trap    <= trap_req;
      end
   end

   assert_user_trap_R1: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && priv_user) |=> (trap && rd_data == '0));
   assert_user_no_change_R1: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && priv_user && !evt_valid) |=>
         ($stable(cause_q) && $stable(mask_q) && $stable(xfer_q)));
   assert_trap_pulse_R11: assert property (@(posedge clk) disable iff (rst)
      !(acc_valid && priv_user) |=> !trap);
   assert_write_rd_zero_R11: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && acc_write) |=> (rd_data == '0));
   assert_wr_blocked_R6: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && acc_write && dbg_en && !in_dbg) |=>
         ($stable(mask_q) && $stable(xfer_q)));
   assert_no_read_no_clear_R3: assert property (@(posedge clk) disable iff (rst)
      (dbg_en && !in_dbg && !evt_valid) |=> $stable(cause_q));
endmodule

// File: tb/dbgreg_guard_tb.sv
module dbgreg_guard_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         acc_valid = 1'b0;
   logic [1:0]   acc_sel = 2'd0;
   logic         acc_write = 1'b0;
   logic [W-1:0] acc_wdata = '0;
   logic         priv_user = 1'b0;
   logic         dbg_en = 1'b0;
   logic         in_dbg = 1'b0;
   logic         evt_valid = 1'b0;
   logic [W-1:0] evt_cause = '0;
   logic         rfi = 1'b0;
   logic [W-1:0] rd_data;
   logic         trap;
   logic         freeze;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   dbgreg_guard #(.W(W)) u_dut (
      .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_sel(acc_sel),
      .acc_write(acc_write), .acc_wdata(acc_wdata), .priv_user(priv_user),
      .dbg_en(dbg_en), .in_dbg(in_dbg), .evt_valid(evt_valid),
      .evt_cause(evt_cause), .rfi(rfi), .rd_data(rd_data), .trap(trap),
      .freeze(freeze)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // drive one access for one cycle; return with results visible
   task automatic access(input bit user, input bit den, input bit idbg,
                         input logic [1:0] sel, input bit wr,
                         input logic [W-1:0] wd);
      @(negedge clk);
      acc_valid = 1'b1; priv_user = user; dbg_en = den; in_dbg = idbg;
      acc_sel = sel; acc_write = wr; acc_wdata = wd;
      @(negedge clk);
      acc_valid = 1'b0; priv_user = 1'b0; dbg_en = 1'b0; in_dbg = 1'b0;
      acc_write = 1'b0;
   endtask

   task automatic peek(input logic [1:0] sel, output logic [W-1:0] v);
      access(1'b0, 1'b1, 1'b0, sel, 1'b0, '0);
      v = rd_data;
   endtask

   task automatic event_pulse(input bit den, input logic [W-1:0] c);
      @(negedge clk);
      evt_valid = 1'b1; evt_cause = c; dbg_en = den;
      @(negedge clk);
      evt_valid = 1'b0; evt_cause = '0; dbg_en = 1'b0;
   endtask

   task automatic rfi_pulse();
      @(negedge clk);
      rfi = 1'b1;
      @(negedge clk);
      rfi = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] v, m, d, c, exp_c, exp_m, exp_d, exp_rd;
      bit rd_ok, clr, wok;
      int idx;

      // R12 reset state
      do_reset();
      check("R12 freeze", freeze, 0);
      check("R12 trap", trap, 0);
      check("R12 rd_data", rd_data, 0);

      // Sweep every access combination (R1..R7, R11)
      idx = 0;
      for (int u = 0; u < 2; u++)
      for (int de = 0; de < 2; de++)
      for (int id = 0; id < 2; id++)
      for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++) begin
         m = 8'h5A ^ W'(idx * 7);
         m[0] = 1'b1;
         d = 8'hC3 ^ W'(idx * 13);
         do_reset();
         access(1'b0, 1'b0, 1'b0, 2'd1, 1'b1, m);
         access(1'b0, 1'b1, 1'b1, 2'd2, 1'b1, d);
         event_pulse(1'b1, 8'hFF);
         exp_c = m; exp_m = m; exp_d = d;
         access(u[0], de[0], id[0], s[1:0], w[0], ~m);
         rd_ok = !u[0] && !w[0] && s != 3;
         exp_rd = !rd_ok ? '0 : (s == 0) ? exp_c : (s == 1) ? exp_m : exp_d;
         clr = rd_ok && s == 0 && (!de[0] || id[0]);
         wok = !u[0] && w[0] && (!de[0] || id[0]);
         check(u[0] ? "R1 trap" : "R11 trap", trap, int'(u[0]));
         check(u[0] ? "R1 rd_data" :
               rd_ok ? (!de[0] ? "R2 rd_data" : id[0] ? "R4 rd_data" : "R3 rd_data")
                     : "R11 rd_data", rd_data, exp_rd);
         if (clr) exp_c = '0;
         if (wok && s == 1) exp_m = ~m;
         if (wok && s == 2 && de[0] && id[0]) exp_d = ~m;
         peek(2'd0, v);
         check(u[0] ? "R1 cause" : !w[0] ? "R2/R3/R4 cause" : "R5/R6/R7 cause",
               v, exp_c);
         peek(2'd1, v);
         check(u[0] ? "R1 mask" : !de[0] ? "R5 mask" : id[0] ? "R7 mask" : "R6 mask",
               v, exp_m);
         peek(2'd2, v);
         check(u[0] ? "R1 xfer" : !de[0] ? "R5 xfer" : id[0] ? "R7 xfer" : "R6 xfer",
               v, exp_d);
         idx++;
      end

      // R11 trap lasts a single cycle
      do_reset();
      access(1'b1, 1'b0, 1'b0, 2'd1, 1'b0, '0);
      check("R11 trap high", trap, 1);
      @(negedge clk);
      check("R11 trap pulse", trap, 0);

      // R8 / R9 freeze sequence
      do_reset();
      access(1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 8'h0F);
      event_pulse(1'b0, 8'h30);
      check("R8 unmasked no freeze", freeze, 0);
      peek(2'd0, v);
      check("R8 unmasked no cause", v, 0);
      event_pulse(1'b0, 8'h03);
      check("R8 freeze set", freeze, 1);
      rfi_pulse();
      check("R9 rfi nonzero keeps freeze", freeze, 1);
      access(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, '0);
      check("R2 clearing read value", rd_data, 8'h03);
      peek(2'd0, v);
      check("R2 cause cleared", v, 0);
      check("R9 freeze still set", freeze, 1);
      rfi_pulse();
      check("R9 rfi zero releases", freeze, 0);

      // nested events
      event_pulse(1'b0, 8'h01);
      event_pulse(1'b0, 8'h02);
      rfi_pulse();
      check("R9 nested keeps freeze", freeze, 1);
      peek(2'd0, v);
      check("R8 nested cause", v, 8'h03);
      access(1'b0, 1'b1, 1'b1, 2'd0, 1'b0, '0);
      rfi_pulse();
      check("R9 nested release", freeze, 0);

      // event while debug enabled: cause set, no freeze
      event_pulse(1'b1, 8'h04);
      check("R8 dbg_en no freeze", freeze, 0);
      peek(2'd0, v);
      check("R8 dbg_en cause", v, 8'h04);

      // R10 clearing read collides with an event
      @(negedge clk);
      acc_valid = 1'b1; acc_sel = 2'd0; acc_write = 1'b0;
      evt_valid = 1'b1; evt_cause = 8'h08; dbg_en = 1'b1; in_dbg = 1'b1;
      @(negedge clk);
      acc_valid = 1'b0; evt_valid = 1'b0; evt_cause = '0;
      dbg_en = 1'b0; in_dbg = 1'b0;
      check("R10 read returns old", rd_data, 8'h04);
      peek(2'd0, v);
      check("R10 event bit survives", v, 8'h08);

      // R9 event and rfi together: set wins
      @(negedge clk);
      rfi = 1'b1; evt_valid = 1'b1; evt_cause = 8'h01;
      @(negedge clk);
      rfi = 1'b0; evt_valid = 1'b0; evt_cause = '0;
      check("R9 set beats release", freeze, 1);

      // R12 reset clears everything
      access(1'b0, 1'b1, 1'b1, 2'd2, 1'b1, 8'hAA);
      do_reset();
      check("R12 freeze after reset", freeze, 0);
      peek(2'd0, v); check("R12 cause", v, 0);
      peek(2'd1, v); check("R12 mask", v, 0);
      peek(2'd2, v); check("R12 xfer", v, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule